// File: doc/BRIEF.md
# Bus Fault Exception Controller

This block sits beside a simple in-order processor core. It decides when a failed bus access or a misaligned access turns into an exception, and it holds what the core needs to build the exception frame. Each terminating bus cycle arrives as a one-cycle access strobe. The strobe carries the access kind, size, function code, address and, for instruction fetches, a prefetch slot tag. Three error sources share the bus-error role: an external error pin, an error line from an on-chip module, and a no-response timeout from a bus watchdog that lives outside the block.

The time at which a fault is reported depends on the access kind. A failed data read or a plain data write is reported straight away. A failed prefetch only marks its slot, and it is reported when the core consumes that word; a flush throws the mark away. A failed buffered (released) write waits for the next instruction boundary or operand attempt. When an exception is requested, the block presents a vector number, a status word and the fault address. These stay frozen until the core acknowledges. A fault during exception entry or during the stack reads of an exception return is a double fault: the block stops and raises a halt output that only reset clears.

Top module: `bus_fault_ctrl`

## Requirements
- R1: A fault on an access is detected when any one of `extBerr`, `modBerr` or `wdogTimeout` is high during the access strobe. Each source alone produces the bus-error vector 8'd2.
- R2: A word (size 1) or long (size 2) access with address bit 0 set is an address error with vector 8'd3, which takes precedence over a bus error on the same access. A byte access (size 0) never raises an address error.
- R3: A fault on a data read (kind 1) or a plain data write (kind 2) raises `excReq` after the second rising edge following the access cycle. Only one such fault waits at a time, and a further one arriving while it waits is dropped.
- R4: A fault on an instruction fetch (kind 0) only marks its slot tag. `excReq` rises after the second edge following a `consumeValid` cycle on that tag, and never before the consume.
- R5: `flush` clears every prefetch mark, so a later consume of a flushed slot raises no request.
- R6: A fault on a released write (kind 3) is held until an `instBoundary` or `opAttempt` strobe, and `excReq` rises after the second edge following that strobe.
- R7: When a released-write fault and a data fault become due at the same edge, the released-write fault is reported first. The data fault is reported after that exception is acknowledged.
- R8: `faultStatus` holds size in bits 7:6, a write flag in bit 5 (set for kinds 2 and 3), the access kind in bits 4:3 and the function code in bits 2:0. `faultAddr` holds the address of the faulting access.
- R9: `excReq` stays high until an `excAck` cycle and falls at that edge. `excVector`, `faultStatus` and `faultAddr` do not change while it is high.
- R10: A fault while `inExcEntry` or `inRteStack` is high sets `halted` at the next edge and drops `excReq`.
- R11: While halted, all fault, consume, flush, trigger and acknowledge inputs are ignored. Only reset clears `halted`, and reset also clears `excReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extBerr | input | 1 | External bus error pin |
| modBerr | input | 1 | Bus error from an internal module |
| wdogTimeout | input | 1 | No-response timeout from the bus watchdog |
| accValid | input | 1 | A bus access terminates this cycle |
| accKind | input | 2 | 0 fetch, 1 data read, 2 data write, 3 released write |
| accSize | input | 2 | 0 byte, 1 word, 2 long |
| accFc | input | 3 | Function code of the access |
| accAddr | input | ADDR_W | Access address |
| accTag | input | TAG_W | Prefetch slot of a fetch access |
| consumeValid | input | 1 | Core consumes a prefetched word |
| consumeTag | input | TAG_W | Slot being consumed |
| flush | input | 1 | Pipeline flush discards all prefetched words |
| instBoundary | input | 1 | Instruction boundary strobe |
| opAttempt | input | 1 | Core attempts an operand access |
| inExcEntry | input | 1 | Core is in bus-error, address-error or reset exception entry |
| inRteStack | input | 1 | Core is reading the stack for an exception return |
| excAck | input | 1 | Core acknowledges the exception request |
| excReq | output | 1 | Exception processing request |
| excVector | output | 8 | Vector number of the reported fault |
| faultStatus | output | 8 | Status word of the faulting access |
| faultAddr | output | ADDR_W | Address of the faulting access |
| halted | output | 1 | Double fault halt |

## Verification
The bench first drives data faults from each error source on its own, then odd-address word accesses against odd-address byte accesses. This separates the OR of the three sources from the alignment check. Fetch faults are followed either by a consume or by a flush and then a consume, which shows that reporting hangs on the consume and not on the fault. Released-write faults are released once by a boundary and once by an operand attempt, and one is made due in the same cycle as a data fault to expose the ordering. The last patterns fault during exception entry and then drive live stimulus into the halted block, which shows that everything but reset is ignored.

// File: rtl/bfec_pkg.sv
package bfec_pkg;
  typedef enum logic [1:0] {
    KIND_FETCH    = 2'd0,
    KIND_READ     = 2'd1,
    KIND_WRITE    = 2'd2,
    KIND_RELWRITE = 2'd3
  } accKind_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;

  localparam logic [7:0] VEC_BUS  = 8'd2;
  localparam logic [7:0] VEC_ADDR = 8'd3;

  typedef struct packed {
    logic [1:0] size;
    logic       isWrite;
    logic [1:0] kind;
    logic [2:0] fc;
  } faultStatus_t;

  typedef enum logic [1:0] {
    SEL_NONE     = 2'd0,
    SEL_RELWRITE = 2'd1,
    SEL_DATA     = 2'd2,
    SEL_FETCH    = 2'd3
  } reportSel_e;

  typedef struct packed {
    logic       addrErr;
    logic       capFetch;
    logic       capRelWrite;
    logic       capData;
    logic       moveFetch;
    reportSel_e loadSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/bfec_control.sv
module bfec_control
  import bfec_pkg::*;
#(
  parameter int TAG_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               extBerr,
  input  logic               modBerr,
  input  logic               wdogTimeout,
  input  logic               accValid,
  input  accKind_e           accKind,
  input  logic [1:0]         accSize,
  input  logic               addrLsb,
  input  logic [TAG_W-1:0]   accTag,
  input  logic               consumeValid,
  input  logic [TAG_W-1:0]   consumeTag,
  input  logic               flush,
  input  logic               instBoundary,
  input  logic               opAttempt,
  input  logic               inExcEntry,
  input  logic               inRteStack,
  input  logic               excAck,
  output ctrlStrobes_t       strobes,
  output logic               excReq,
  output logic               halted
);
  localparam int NUM_TAGS = 1 << TAG_W;

  logic                berrAny, misaligned, faultNow, doubleFault, acceptFault;
  logic                trig, consumeHit;
  logic [NUM_TAGS-1:0] markV, markNext;
  logic                rwV, rwDue, dataV, fetchDueV, reqQ, haltQ;
  reportSel_e          sel;

  always_comb begin
    berrAny     = extBerr | modBerr | wdogTimeout;
    misaligned  = (accSize != SZ_BYTE) && addrLsb;
    faultNow    = accValid && (berrAny || misaligned) && !haltQ;
    doubleFault = faultNow && (inExcEntry || inRteStack);
    acceptFault = faultNow && !doubleFault;
    trig        = instBoundary || opAttempt;
    consumeHit  = consumeValid && markV[consumeTag] && !haltQ;

    sel = SEL_NONE;
    if (!reqQ && !haltQ) begin
      if (rwDue)          sel = SEL_RELWRITE;
      else if (dataV)     sel = SEL_DATA;
      else if (fetchDueV) sel = SEL_FETCH;
    end

    strobes.addrErr     = misaligned;
    strobes.capFetch    = acceptFault && (accKind == KIND_FETCH);
    strobes.capData     = acceptFault && (accKind == KIND_READ || accKind == KIND_WRITE) && !dataV;
    strobes.capRelWrite = acceptFault && (accKind == KIND_RELWRITE) && !rwV;
    strobes.moveFetch   = consumeHit;
    strobes.loadSel     = sel;
  end

  always_comb begin
    markNext = markV;
    if (consumeHit) markNext[consumeTag] = 1'b0;
    if (flush) markNext = '0;
    if (strobes.capFetch) markNext[accTag] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      markV     <= '0;
      rwV       <= 1'b0;
      rwDue     <= 1'b0;
      dataV     <= 1'b0;
      fetchDueV <= 1'b0;
      reqQ      <= 1'b0;
      haltQ     <= 1'b0;
    end else if (doubleFault) begin
      haltQ <= 1'b1;
      reqQ  <= 1'b0;
    end else if (!haltQ) begin
      markV <= markNext;
      if (reqQ && excAck)      reqQ <= 1'b0;
      else if (sel != SEL_NONE) reqQ <= 1'b1;
      if (strobes.capRelWrite)     rwV <= 1'b1;
      else if (sel == SEL_RELWRITE) rwV <= 1'b0;
      rwDue <= (rwDue || (rwV && trig)) && (sel != SEL_RELWRITE);
      if (strobes.capData)      dataV <= 1'b1;
      else if (sel == SEL_DATA) dataV <= 1'b0;
      if (consumeHit)            fetchDueV <= 1'b1;
      else if (sel == SEL_FETCH) fetchDueV <= 1'b0;
    end
  end

  assign excReq = reqQ;
  assign halted = haltQ;

  // R9: request holds until acknowledged
  p_req_held_r9: assert property (@(posedge clk) disable iff (!rstN)
    (excReq && !excAck && !halted && !inExcEntry && !inRteStack) |=> excReq);

  // R11: halt is left only through reset
  p_halt_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted);

  // R10: no request while halted
  p_halt_no_req_r10: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !excReq);

  // R7: a data fault loses to a due released write and keeps waiting
  p_data_waits_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rwDue && dataV && !excReq && !halted && !doubleFault) |=> (dataV && excReq));
endmodule

// File: rtl/bfec_datapath.sv
module bfec_datapath
  import bfec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  accKind_e          accKind,
  input  logic [1:0]        accSize,
  input  logic [2:0]        accFc,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [TAG_W-1:0]  accTag,
  input  logic [TAG_W-1:0]  consumeTag,
  output logic [7:0]        excVector,
  output faultStatus_t      faultStatus,
  output logic [ADDR_W-1:0] faultAddr
);
  localparam int NUM_TAGS = 1 << TAG_W;

  logic [7:0]        newVec;
  faultStatus_t      newStat;

  logic [7:0]        fetchVec  [NUM_TAGS];
  faultStatus_t      fetchStat [NUM_TAGS];
  logic [ADDR_W-1:0] fetchAddr [NUM_TAGS];

  logic [7:0]        rwVec, dataVec, dueVec;
  faultStatus_t      rwStat, dataStat, dueStat;
  logic [ADDR_W-1:0] rwAddr, dataAddr, dueAddr;

  always_comb begin
    newVec          = strobes.addrErr ? VEC_ADDR : VEC_BUS;
    newStat.size    = accSize;
    newStat.isWrite = (accKind == KIND_WRITE) || (accKind == KIND_RELWRITE);
    newStat.kind    = accKind;
    newStat.fc      = accFc;
  end

  for (genvar t = 0; t < NUM_TAGS; t++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        fetchVec[t]  <= '0;
        fetchStat[t] <= '0;
        fetchAddr[t] <= '0;
      end else if (strobes.capFetch && accTag == TAG_W'(t)) begin
        fetchVec[t]  <= newVec;
        fetchStat[t] <= newStat;
        fetchAddr[t] <= accAddr;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rwVec   <= '0; rwStat   <= '0; rwAddr   <= '0;
      dataVec <= '0; dataStat <= '0; dataAddr <= '0;
      dueVec  <= '0; dueStat  <= '0; dueAddr  <= '0;
      excVector <= '0; faultStatus <= '0; faultAddr <= '0;
    end else begin
      if (strobes.capRelWrite) begin
        rwVec <= newVec; rwStat <= newStat; rwAddr <= accAddr;
      end
      if (strobes.capData) begin
        dataVec <= newVec; dataStat <= newStat; dataAddr <= accAddr;
      end
      if (strobes.moveFetch) begin
        dueVec  <= fetchVec[consumeTag];
        dueStat <= fetchStat[consumeTag];
        dueAddr <= fetchAddr[consumeTag];
      end
      case (strobes.loadSel)
        SEL_RELWRITE: begin excVector <= rwVec;   faultStatus <= rwStat;   faultAddr <= rwAddr;   end
        SEL_DATA:     begin excVector <= dataVec; faultStatus <= dataStat; faultAddr <= dataAddr; end
        SEL_FETCH:    begin excVector <= dueVec;  faultStatus <= dueStat;  faultAddr <= dueAddr;  end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bus_fault_ctrl.sv
module bus_fault_ctrl
  import bfec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extBerr,
  input  logic              modBerr,
  input  logic              wdogTimeout,
  input  logic              accValid,
  input  logic [1:0]        accKind,
  input  logic [1:0]        accSize,
  input  logic [2:0]        accFc,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [TAG_W-1:0]  accTag,
  input  logic              consumeValid,
  input  logic [TAG_W-1:0]  consumeTag,
  input  logic              flush,
  input  logic              instBoundary,
  input  logic              opAttempt,
  input  logic              inExcEntry,
  input  logic              inRteStack,
  input  logic              excAck,
  output logic              excReq,
  output logic [7:0]        excVector,
  output logic [7:0]        faultStatus,
  output logic [ADDR_W-1:0] faultAddr,
  output logic              halted
);
  ctrlStrobes_t strobes;
  faultStatus_t statWord;
  accKind_e     kindE;

  assign kindE       = accKind_e'(accKind);
  assign faultStatus = statWord;

  bfec_control #(.TAG_W(TAG_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .extBerr(extBerr), .modBerr(modBerr), .wdogTimeout(wdogTimeout),
    .accValid(accValid), .accKind(kindE), .accSize(accSize), .addrLsb(accAddr[0]),
    .accTag(accTag), .consumeValid(consumeValid), .consumeTag(consumeTag),
    .flush(flush), .instBoundary(instBoundary), .opAttempt(opAttempt),
    .inExcEntry(inExcEntry), .inRteStack(inRteStack), .excAck(excAck),
    .strobes(strobes), .excReq(excReq), .halted(halted)
  );

  bfec_datapath #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .accKind(kindE), .accSize(accSize), .accFc(accFc), .accAddr(accAddr),
    .accTag(accTag), .consumeTag(consumeTag),
    .excVector(excVector), .faultStatus(statWord), .faultAddr(faultAddr)
  );

  // R9: the reported record is frozen while the request is held
  p_report_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    (excReq && $past(excReq)) |-> ($stable(excVector) && $stable(faultStatus) && $stable(faultAddr)));

  // R2: only the two defined vectors are ever presented
  p_vector_legal_r2: assert property (@(posedge clk) disable iff (!rstN)
    excReq |-> (excVector == VEC_BUS || excVector == VEC_ADDR));
endmodule

// File: tb/tb_bus_fault_ctrl.sv
module tb_bus_fault_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extBerr = 0, modBerr = 0, wdogTimeout = 0, accValid = 0;
  logic [1:0] accKind = 0, accSize = 0;
  logic [2:0] accFc = 0;
  logic [31:0] accAddr = 0;
  logic [1:0] accTag = 0, consumeTag = 0;
  logic consumeValid = 0, flush = 0, instBoundary = 0, opAttempt = 0;
  logic inExcEntry = 0, inRteStack = 0, excAck = 0;
  logic excReq, halted;
  logic [7:0] excVector, faultStatus;
  logic [31:0] faultAddr;

  int checks = 0, errors = 0;
  string curReq = "R11";
  bit done = 0;

  always #2 clk = ~clk;

  bus_fault_ctrl dut (
    .clk(clk), .rstN(rstN), .extBerr(extBerr), .modBerr(modBerr), .wdogTimeout(wdogTimeout),
    .accValid(accValid), .accKind(accKind), .accSize(accSize), .accFc(accFc), .accAddr(accAddr),
    .accTag(accTag), .consumeValid(consumeValid), .consumeTag(consumeTag), .flush(flush),
    .instBoundary(instBoundary), .opAttempt(opAttempt), .inExcEntry(inExcEntry),
    .inRteStack(inRteStack), .excAck(excAck), .excReq(excReq), .excVector(excVector),
    .faultStatus(faultStatus), .faultAddr(faultAddr), .halted(halted)
  );

  // Behavioural reference: records are {vector, status, address}
  bit mHalt, mReq, mRw, mRwDue, mData, mPf;
  logic [47:0] mRep, rwR, dataR, pfR;
  bit mMark[4];
  logic [47:0] mkR[4];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mHalt = 0; mReq = 0; mRw = 0; mRwDue = 0; mData = 0; mPf = 0;
      mRep = '0;
      for (int i = 0; i < 4; i++) mMark[i] = 0;
    end else if (!mHalt) begin
      bit mis, f, capD, capW, dueSet, hit;
      int pick;
      logic [47:0] rec;
      mis = (accSize != 0) && accAddr[0];
      f = accValid && (extBerr || modBerr || wdogTimeout || mis);
      if (f && (inExcEntry || inRteStack)) begin
        mHalt = 1; mReq = 0;
      end else begin
        rec = {(mis ? 8'd3 : 8'd2), accSize, (accKind >= 2'd2), accKind, accFc, accAddr};
        pick = 0;
        if (!mReq) begin
          if (mRwDue) pick = 1; else if (mData) pick = 2; else if (mPf) pick = 3;
        end
        capD = f && (accKind == 1 || accKind == 2) && !mData;
        capW = f && accKind == 3 && !mRw;
        dueSet = mRw && (instBoundary || opAttempt);
        hit = consumeValid && mMark[consumeTag];
        if (mReq && excAck) mReq = 0; else if (pick != 0) mReq = 1;
        if (pick == 1) begin mRep = rwR;   mRw = 0; mRwDue = 0; end
        if (pick == 2) begin mRep = dataR; mData = 0; end
        if (pick == 3) begin mRep = pfR;   mPf = 0; end
        if (dueSet && pick != 1) mRwDue = 1;
        if (capD) begin mData = 1; dataR = rec; end
        if (capW) begin mRw = 1; rwR = rec; end
        if (hit) begin mPf = 1; pfR = mkR[consumeTag]; mMark[consumeTag] = 0; end
        if (flush) for (int i = 0; i < 4; i++) mMark[i] = 0;
        if (f && accKind == 0) begin mMark[accTag] = 1; mkR[accTag] = rec; end
      end
    end
  end

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      check(curReq, "excReq", excReq, mReq);
      check(curReq, "halted", halted, mHalt);
      if (mReq) check(curReq, "record", {excVector, faultStatus, faultAddr}, mRep);
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic clearIn();
    extBerr = 0; modBerr = 0; wdogTimeout = 0; accValid = 0;
    consumeValid = 0; flush = 0; instBoundary = 0; opAttempt = 0; excAck = 0;
  endtask

  task automatic access(logic [1:0] kind, logic [1:0] size, logic [2:0] fc,
                        logic [31:0] addr, logic [1:0] tag, logic [2:0] src);
    accValid = 1; accKind = kind; accSize = size; accFc = fc; accAddr = addr; accTag = tag;
    extBerr = src[0]; modBerr = src[1]; wdogTimeout = src[2];
    tick(); clearIn();
  endtask

  task automatic ack();
    excAck = 1; tick(); clearIn();
  endtask

  task automatic doReset();
    rstN = 0; tick(3); rstN = 1; tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); doReset();
    curReq = "R11";
    #1 check("R11", "reset excReq", excReq, 0);
    check("R11", "reset halted", halted, 0);
    tick();

    // R1: each source alone on a data read
    curReq = "R1";
    for (int s = 0; s < 3; s++) begin
      access(2'd1, 2'd1, 3'd1, 32'h100 + 32'(s) * 4, 2'd0, 3'(1 << s));
      tick(2);
      check("R1", "vector", excVector, 8'd2);
      ack(); tick(2);
    end

    // R2: misaligned word vs byte
    curReq = "R2";
    access(2'd1, 2'd1, 3'd2, 32'h201, 2'd0, 3'd0);
    tick(2);
    check("R2", "odd word vector", excVector, 8'd3);
    ack(); tick(2);
    access(2'd1, 2'd0, 3'd2, 32'h203, 2'd0, 3'd0);
    tick(4);
    check("R2", "odd byte no request", excReq, 0);

    // R3: two-edge latency
    curReq = "R3";
    accValid = 1; accKind = 2'd2; accSize = 2'd2; accAddr = 32'h300; extBerr = 1;
    @(posedge clk); #1; clearIn();
    @(negedge clk); check("R3", "after first edge", excReq, 0);
    @(posedge clk); #1;
    @(negedge clk); check("R3", "after second edge", excReq, 1);
    #1 ack(); tick(2);

    // R4: fetch fault reported on consume only
    curReq = "R4";
    access(2'd0, 2'd1, 3'd6, 32'h400, 2'd1, 3'd4);
    tick(4);
    check("R4", "no request before consume", excReq, 0);
    consumeValid = 1; consumeTag = 2'd1; tick(); clearIn();
    tick(1);
    check("R4", "request after consume", excReq, 1);
    check("R4", "fetch address", faultAddr, 32'h400);
    ack(); tick(2);

    // R5: flushed mark is dropped
    curReq = "R5";
    access(2'd0, 2'd1, 3'd6, 32'h500, 2'd2, 3'd1);
    flush = 1; tick(); clearIn();
    consumeValid = 1; consumeTag = 2'd2; tick(); clearIn();
    tick(4);
    check("R5", "no request after flush", excReq, 0);

    // R6: released write by boundary, then by operand attempt
    curReq = "R6";
    access(2'd3, 2'd1, 3'd1, 32'h600, 2'd0, 3'd2);
    tick(4);
    check("R6", "held before boundary", excReq, 0);
    instBoundary = 1; tick(); clearIn(); tick();
    check("R6", "after boundary", excReq, 1);
    ack(); tick(2);
    access(2'd3, 2'd1, 3'd1, 32'h610, 2'd0, 3'd1);
    tick(2);
    opAttempt = 1; tick(); clearIn(); tick();
    check("R6", "after operand attempt", excReq, 1);
    check("R6", "address", faultAddr, 32'h610);
    ack(); tick(2);

    // R7: released write beats a data fault due at the same edge
    curReq = "R7";
    access(2'd3, 2'd2, 3'd1, 32'h700, 2'd0, 3'd1);
    instBoundary = 1; accValid = 1; accKind = 2'd1; accSize = 2'd1; accAddr = 32'h780; extBerr = 1;
    tick(); clearIn(); tick();
    check("R7", "first is released write", faultAddr, 32'h700);
    tick(3);
    check("R7", "still first before ack", faultAddr, 32'h700);
    ack(); tick();
    check("R7", "second is data", faultAddr, 32'h780);
    ack(); tick(2);

    // R8: status word layout
    curReq = "R8";
    access(2'd2, 2'd2, 3'd5, 32'h1000, 2'd0, 3'd2);
    tick(2);
    check("R8", "status", faultStatus, 8'hB5);
    check("R8", "address", faultAddr, 32'h1000);
    curReq = "R9";
    tick(5);
    check("R9", "held without ack", excReq, 1);
    check("R9", "status stable", faultStatus, 8'hB5);
    ack();
    check("R9", "falls after ack", excReq, 0);
    tick(2);

    // R10: double fault during exception entry
    curReq = "R10";
    inExcEntry = 1;
    access(2'd1, 2'd1, 3'd5, 32'h1100, 2'd0, 3'd1);
    inExcEntry = 0;
    check("R10", "halted", halted, 1);
    check("R10", "no request", excReq, 0);

    // R11: halted ignores all else
    curReq = "R11";
    access(2'd1, 2'd1, 3'd5, 32'h1200, 2'd0, 3'd1);
    access(2'd3, 2'd1, 3'd5, 32'h1204, 2'd0, 3'd1);
    instBoundary = 1; excAck = 1; flush = 1; tick(); clearIn();
    tick(3);
    check("R11", "still halted", halted, 1);
    check("R11", "no request while halted", excReq, 0);
    doReset();
    check("R11", "reset leaves halt", halted, 0);
    check("R11", "no request after reset", excReq, 0);

    // R10: double fault during exception return stack reads
    curReq = "R10";
    inRteStack = 1;
    access(2'd1, 2'd1, 3'd5, 32'h1300, 2'd0, 3'd4);
    inRteStack = 0;
    check("R10", "halted on return", halted, 1);
    tick(2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule